// File: doc/BRIEF.md
# Reorder Buffer with Future File

This block gives a scalar core that runs instructions out of order an in-order commit point and precise faults. It keeps a small circular queue of in-flight instructions and a future file. The future file holds the newest speculative value of each architectural register, together with a flag that says whether that value has arrived yet. The decode stage allocates one queue slot per instruction through a valid/ready handshake and receives the slot index. Functional units later return a result for that index, along with a fault flag. Decode reads its operands straight from the future file. No associative search of the queue takes place.

Finished instructions leave the queue from the oldest slot, one at most per cycle, and each one writes an architectural register file kept inside the block. The oldest slot may finish with its fault flag set. In that case the block raises a flush pulse, empties the queue and reloads every future-file register from the architectural file. This rolls the machine back to the state just before the faulting instruction. While all slots are occupied, the block tells fetch to stop.

Back-pressure applies only on allocation. A slot is taken on a clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while the queue is full or a flush is being signalled. Requests offered while it is low leave no trace. Writebacks are always accepted and carry no ready signal. The retire and flush outputs describe what the coming clock edge will do.

Top module: `rob_future_file`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `fetch_stall`, `retire_valid` and `exc_flush` are 0, and every register reads back valid with value 0.
- R2: Slots are handed out in order 0, 1, 2, 3, then 0 again. `alloc_idx` shows the slot the next allocation will take. After an allocation, its destination register reads back not valid.
- R3: With four instructions in flight, `alloc_ready` is 0 and `fetch_stall` is 1. An allocation offered then changes neither `alloc_idx` nor the state of the register it names.
- R4: A writeback from the newest producer of a register makes that register read back valid with the written value from the next cycle on.
- R5: A writeback from a producer that a later allocation has superseded for the same register leaves that register not valid.
- R6: Only the oldest slot can retire, and only once its result has arrived. Younger slots that are already complete wait for it. Slots retire in allocation order, each with its destination and value on `retire_rd` and `retire_value`.
- R7: At most one slot retires per clock cycle.
- R8: When the oldest slot is complete and flagged as faulting, `exc_flush` is 1 and `retire_valid` is 0 for that cycle. On the next cycle the queue is empty and `alloc_idx` is 0. Every register then reads back valid with its last retired value, so speculative results are discarded.
- R9: A faulting instruction never updates the architectural file: after the flush its destination holds the value it had before.
- R10: A writeback naming a slot that is not in use changes no register and causes no retirement.
- R11: If a writeback and a new allocation hit the same register in the same cycle, the allocation wins and the register reads back not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_op | input | 2 | Opcode: 0 add, 1 divide, 2 load |
| alloc_rd | input | 4 | Destination register |
| alloc_rs | input | 4 | First source register name |
| alloc_rt | input | 4 | Second source register name |
| alloc_idx | output | 2 | Slot the next allocation receives |
| wb_valid | input | 1 | A result is returned |
| wb_idx | input | 2 | Slot the result belongs to |
| wb_value | input | 32 | Result value |
| wb_exc | input | 1 | The instruction faulted |
| src_a_reg | input | 4 | Operand read port A register |
| src_a_valid | output | 1 | Port A value is present |
| src_a_value | output | 32 | Port A value |
| src_b_reg | input | 4 | Operand read port B register |
| src_b_valid | output | 1 | Port B value is present |
| src_b_value | output | 32 | Port B value |
| retire_valid | output | 1 | Oldest slot commits at the coming edge |
| retire_op | output | 2 | Opcode of the committing slot |
| retire_rd | output | 4 | Destination of the committing slot |
| retire_rs | output | 4 | First source name of the committing slot |
| retire_rt | output | 4 | Second source name of the committing slot |
| retire_value | output | 32 | Value written to the architectural file |
| exc_flush | output | 1 | Oldest slot faulted; queue and future file are restored at the coming edge |
| fetch_stall | output | 1 | All slots occupied |

## Verification
The core pattern fills all four slots with distinct destinations and returns the results youngest first. This separates true in-order commit from commit in completion order, and it shows the register file updating ahead of commit. A second pattern allocates the same register twice and returns the older result late, sometimes in the same cycle as a newer allocation. This separates correct ownership tracking from a last-writer-wins file. A third pattern faults the middle instruction of three while a younger result is already in the future file. The reload after the flush must then bring back retired values and drop the younger speculative one. Writebacks aimed at a free slot and allocations attempted while the queue is full cover the inputs that must have no effect.

// File: rtl/rob_ff_pkg.sv
package rob_ff_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_DIV  = 2'd1,
    OP_LOAD = 2'd2
  } op_t;
endpackage

// File: rtl/rob_ff_table.sv
module rob_ff_table
  import rob_ff_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NREG  = 12,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [1:0]    alloc_op,
  input  logic [RW-1:0] alloc_rd,
  input  logic [RW-1:0] alloc_rs,
  input  logic [RW-1:0] alloc_rt,
  input  logic          wb_valid,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_value,
  input  logic          wb_exc,
  input  logic          retire_fire,
  input  logic          flush,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          head_done,
  output logic          head_exc,
  output logic [1:0]    head_op,
  output logic [RW-1:0] head_rd,
  output logic [RW-1:0] head_rs,
  output logic [RW-1:0] head_rt,
  output logic [DW-1:0] head_val,
  output logic          wb_hit,
  output logic [RW-1:0] wb_rd
);
  logic [IW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          e_v   [DEPTH];
  logic          e_exc [DEPTH];
  logic          e_rdy [DEPTH];
  op_t           e_op  [DEPTH];
  logic [RW-1:0] e_rd  [DEPTH];
  logic [RW-1:0] e_rs  [DEPTH];
  logic [RW-1:0] e_rt  [DEPTH];
  logic [DW-1:0] e_val [DEPTH];

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_v[i]   <= 1'b0;
        e_rdy[i] <= 1'b0;
        e_exc[i] <= 1'b0;
        e_op[i]  <= OP_ADD;
        e_rd[i]  <= '0;
        e_rs[i]  <= '0;
        e_rt[i]  <= '0;
        e_val[i] <= '0;
      end
    end else begin
      if (wb_hit) begin
        e_val[wb_idx] <= wb_value;
        e_rdy[wb_idx] <= 1'b1;
        e_exc[wb_idx] <= wb_exc;
      end
      if (retire_fire) begin
        e_v[head]   <= 1'b0;
        e_rdy[head] <= 1'b0;
        head        <= step(head);
      end
      if (alloc_fire) begin
        e_v[tail]   <= 1'b1;
        e_rdy[tail] <= 1'b0;
        e_exc[tail] <= 1'b0;
        e_op[tail]  <= op_t'(alloc_op);
        e_rd[tail]  <= alloc_rd;
        e_rs[tail]  <= alloc_rs;
        e_rt[tail]  <= alloc_rt;
        e_val[tail] <= '0;
        tail        <= step(tail);
      end
      case ({alloc_fire, retire_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign tail_idx  = tail;
  assign full      = (cnt == CW'(DEPTH));
  assign head_done = e_v[head] && e_rdy[head];
  assign head_exc  = e_exc[head];
  assign head_op   = e_op[head];
  assign head_rd   = e_rd[head];
  assign head_rs   = e_rs[head];
  assign head_rt   = e_rt[head];
  assign head_val  = e_val[head];
  assign wb_hit    = wb_valid && e_v[wb_idx];
  assign wb_rd     = e_rd[wb_idx];
endmodule

// File: rtl/rob_ff_regs.sv
module rob_ff_regs #(
  parameter int DEPTH = 4,
  parameter int NREG  = 12,
  parameter int DW    = 32,
  parameter int NRP   = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_fire,
  input  logic [RW-1:0]           alloc_rd,
  input  logic [IW-1:0]           alloc_idx,
  input  logic                    wb_hit,
  input  logic [RW-1:0]           wb_rd,
  input  logic [IW-1:0]           wb_idx,
  input  logic [DW-1:0]           wb_value,
  input  logic                    commit,
  input  logic [RW-1:0]           commit_rd,
  input  logic [DW-1:0]           commit_value,
  input  logic                    flush,
  input  logic [NRP-1:0][RW-1:0]  rd_reg,
  output logic [NRP-1:0]          rd_valid,
  output logic [NRP-1:0][DW-1:0]  rd_value
);
  logic [DW-1:0] spec_val [NREG];
  logic          spec_v   [NREG];
  logic [IW-1:0] owner    [NREG];
  logic [DW-1:0] arch     [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        spec_val[i] <= '0;
        spec_v[i]   <= 1'b1;
        owner[i]    <= '0;
        arch[i]     <= '0;
      end
    end else begin
      if (commit) arch[commit_rd] <= commit_value;
      if (flush) begin
        for (int i = 0; i < NREG; i++) begin
          spec_val[i] <= arch[i];
          spec_v[i]   <= 1'b1;
        end
      end else begin
        if (wb_hit && owner[wb_rd] == wb_idx) begin
          spec_val[wb_rd] <= wb_value;
          spec_v[wb_rd]   <= 1'b1;
        end
        if (alloc_fire) begin
          spec_v[alloc_rd] <= 1'b0;
          owner[alloc_rd]  <= alloc_idx;
        end
      end
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_port
    assign rd_valid[p] = (rd_reg[p] < RW'(NREG)) ? spec_v[rd_reg[p]] : 1'b1;
    assign rd_value[p] = (rd_reg[p] < RW'(NREG)) ? spec_val[rd_reg[p]] : '0;
  end
endmodule

// File: rtl/rob_future_file.sv
module rob_future_file #(
  parameter int DEPTH = 4,
  parameter int NREG  = 12,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [1:0]    alloc_op,
  input  logic [RW-1:0] alloc_rd,
  input  logic [RW-1:0] alloc_rs,
  input  logic [RW-1:0] alloc_rt,
  output logic [IW-1:0] alloc_idx,
  input  logic          wb_valid,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_value,
  input  logic          wb_exc,
  input  logic [RW-1:0] src_a_reg,
  output logic          src_a_valid,
  output logic [DW-1:0] src_a_value,
  input  logic [RW-1:0] src_b_reg,
  output logic          src_b_valid,
  output logic [DW-1:0] src_b_value,
  output logic          retire_valid,
  output logic [1:0]    retire_op,
  output logic [RW-1:0] retire_rd,
  output logic [RW-1:0] retire_rs,
  output logic [RW-1:0] retire_rt,
  output logic [DW-1:0] retire_value,
  output logic          exc_flush,
  output logic          fetch_stall
);
  logic          full, head_done, head_exc, alloc_fire, wb_hit;
  logic [RW-1:0] wb_rd;
  logic [1:0]          port_valid;
  logic [1:0][RW-1:0]  port_reg;
  logic [1:0][DW-1:0]  port_value;

  assign retire_valid = head_done && !head_exc;
  assign exc_flush    = head_done && head_exc;
  assign alloc_ready  = !full && !exc_flush;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign fetch_stall  = full;

  rob_ff_table #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_op(alloc_op), .alloc_rd(alloc_rd),
    .alloc_rs(alloc_rs), .alloc_rt(alloc_rt),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value), .wb_exc(wb_exc),
    .retire_fire(retire_valid), .flush(exc_flush),
    .tail_idx(alloc_idx), .full(full),
    .head_done(head_done), .head_exc(head_exc), .head_op(retire_op),
    .head_rd(retire_rd), .head_rs(retire_rs), .head_rt(retire_rt),
    .head_val(retire_value), .wb_hit(wb_hit), .wb_rd(wb_rd)
  );

  assign port_reg    = {src_b_reg, src_a_reg};
  assign src_a_valid = port_valid[0];
  assign src_b_valid = port_valid[1];
  assign src_a_value = port_value[0];
  assign src_b_value = port_value[1];

  rob_ff_regs #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .NRP(2)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_rd(alloc_rd), .alloc_idx(alloc_idx),
    .wb_hit(wb_hit), .wb_rd(wb_rd), .wb_idx(wb_idx), .wb_value(wb_value),
    .commit(retire_valid), .commit_rd(retire_rd), .commit_value(retire_value),
    .flush(exc_flush),
    .rd_reg(port_reg), .rd_valid(port_valid), .rd_value(port_value)
  );
endmodule

// File: rtl/rob_ff_checker.sv
module rob_ff_checker #(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [IW-1:0] alloc_idx,
  input logic          retire_valid,
  input logic          exc_flush,
  input logic          fetch_stall
);
  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  AST_IDX_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> alloc_idx == nxt($past(alloc_idx))); // R2
  AST_FULL_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready && !exc_flush |=> $stable(alloc_idx)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !alloc_ready); // R3
  AST_FLUSH_NOT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_valid && exc_flush)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> alloc_ready && alloc_idx == '0 && !retire_valid && !exc_flush); // R8
endmodule

bind rob_future_file rob_ff_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_idx(alloc_idx), .retire_valid(retire_valid), .exc_flush(exc_flush),
  .fetch_stall(fetch_stall)
);

// File: tb/rob_future_file_tb.sv
module rob_future_file_tb;
  import rob_ff_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_ready;
  logic [1:0]  alloc_op;
  logic [3:0]  alloc_rd, alloc_rs, alloc_rt;
  logic [1:0]  alloc_idx;
  logic        wb_valid, wb_exc;
  logic [1:0]  wb_idx;
  logic [31:0] wb_value;
  logic [3:0]  src_a_reg, src_b_reg;
  logic        src_a_valid, src_b_valid;
  logic [31:0] src_a_value, src_b_value;
  logic        retire_valid, exc_flush, fetch_stall;
  logic [1:0]  retire_op;
  logic [3:0]  retire_rd, retire_rs, retire_rt;
  logic [31:0] retire_value;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0]  V_RD  [4] = '{4'd3, 4'd7, 4'd1, 4'd10};
  localparam logic [31:0] V_VAL [4] = '{32'd100, 32'd200, 32'd300, 32'd400};

  always #4 clk = ~clk;

  rob_future_file u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [3:0] r, output logic v, output logic [31:0] val);
    src_a_reg = r;
    #1;
    v   = src_a_valid;
    val = src_a_value;
  endtask

  task automatic alloc(input logic [3:0] rd, input logic [1:0] op);
    alloc_valid = 1'b1; alloc_rd = rd; alloc_op = op;
    alloc_rs = rd + 4'd1; alloc_rt = rd + 4'd2;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic wback(input logic [1:0] idx, input logic [31:0] val, input logic ex);
    wb_valid = 1'b1; wb_idx = idx; wb_value = val; wb_exc = ex;
    tick();
    wb_valid = 1'b0; wb_exc = 1'b0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic        v;
    logic [31:0] val;
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_op = '0; alloc_rd = '0; alloc_rs = '0;
    alloc_rt = '0; wb_valid = 1'b0; wb_idx = '0; wb_value = '0; wb_exc = 1'b0;
    src_a_reg = '0; src_b_reg = 4'd11;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 fetch_stall", fetch_stall, 0);
    chk("R1 retire_valid", retire_valid, 0);
    chk("R1 exc_flush", exc_flush, 0);
    peek(4'd0, v, val);
    chk("R1 r0 valid", v, 1);
    chk("R1 r0 value", val, 0);
    chk("R1 r11 valid", src_b_valid, 1);
    chk("R1 r11 value", src_b_value, 0);

    // Table walk: fill all slots, return results youngest first
    for (int i = 0; i < 4; i++) begin
      chk("R2 slot order", alloc_idx, i);
      alloc(V_RD[i], OP_ADD);
      peek(V_RD[i], v, val);
      chk("R2 dest pending", v, 0);
    end
    chk("R3 full ready", alloc_ready, 0);
    chk("R3 full stall", fetch_stall, 1);
    alloc(4'd5, OP_ADD);
    chk("R3 idx unchanged", alloc_idx, 0);
    peek(4'd5, v, val);
    chk("R3 r5 untouched", v, 1);
    for (int i = 3; i >= 0; i--) begin
      wback(2'(i), V_VAL[i], 1'b0);
      peek(V_RD[i], v, val);
      chk("R4 value valid", v, 1);
      chk("R4 value", val, V_VAL[i]);
      chk("R6 wait for head", retire_valid, (i == 0) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) begin
      chk("R6 retire valid", retire_valid, 1);
      chk("R6 retire rd", retire_rd, V_RD[i]);
      chk("R7 one per cycle value", retire_value, V_VAL[i]);
      tick();
    end
    chk("R6 drained", retire_valid, 0);
    chk("R3 ready again", alloc_ready, 1);

    // R5 stale producer, R11 same-cycle collision
    alloc(4'd4, OP_LOAD);
    alloc(4'd4, OP_ADD);
    wback(2'd0, 32'd55, 1'b0);
    peek(4'd4, v, val);
    chk("R5 stale write ignored", v, 0);
    chk("R6 head retires rd", retire_rd, 4);
    wback(2'd1, 32'd66, 1'b0);
    peek(4'd4, v, val);
    chk("R4 newest producer valid", v, 1);
    chk("R4 newest producer value", val, 66);
    alloc(4'd6, OP_ADD);
    alloc_valid = 1'b1; alloc_rd = 4'd6; alloc_op = OP_ADD;
    wb_valid = 1'b1; wb_idx = 2'd2; wb_value = 32'd77;
    tick();
    alloc_valid = 1'b0; wb_valid = 1'b0;
    peek(4'd6, v, val);
    chk("R11 allocation wins", v, 0);
    wback(2'd3, 32'd88, 1'b0);
    peek(4'd6, v, val);
    chk("R4 r6 value", val, 88);
    tick(); tick(); tick();
    chk("R6 queue empty", retire_valid, 0);

    // R10 writeback to a free slot
    wback(2'd1, 32'd999, 1'b0);
    peek(4'd4, v, val);
    chk("R10 r4 unchanged", val, 66);
    chk("R10 r4 valid", v, 1);
    chk("R10 no retire", retire_valid, 0);

    // R8 / R9 fault on the middle instruction
    chk("R2 wrap idx", alloc_idx, 0);
    alloc(4'd2, OP_ADD);
    alloc(4'd3, OP_DIV);
    alloc(4'd9, OP_LOAD);
    wback(2'd0, 32'd5, 1'b0);
    wback(2'd2, 32'd9, 1'b0);
    peek(4'd9, v, val);
    chk("R4 r9 speculative", val, 9);
    wback(2'd1, 32'd0, 1'b1);
    chk("R8 flush raised", exc_flush, 1);
    chk("R8 no retire on fault", retire_valid, 0);
    chk("R8 no alloc during flush", alloc_ready, 0);
    tick();
    chk("R8 flush done", exc_flush, 0);
    chk("R8 ready after flush", alloc_ready, 1);
    chk("R8 idx reset", alloc_idx, 0);
    peek(4'd3, v, val);
    chk("R9 faulting dest valid", v, 1);
    chk("R9 faulting dest keeps old", val, 100);
    peek(4'd9, v, val);
    chk("R8 speculative dropped", val, 0);
    chk("R8 speculative valid", v, 1);
    peek(4'd2, v, val);
    chk("R8 retired kept", val, 5);
    peek(4'd7, v, val);
    chk("R8 older retired kept", val, 200);

    report();
  end
endmodule